// File: doc/BRIEF.md
# Calibrated real-time clock core

This block keeps wall-clock time as a 32-bit count of seconds. Each second is built from pulses on a tick-enable input, which the surrounding chip derives from a slow oscillator. Software programs how many tick pulses make one second. An optional fraction, counted in sixteenths of a tick, corrects oscillator error that a whole number of ticks cannot express. When the fraction is enabled, a 4-bit accumulator adds it once per second, and each second in which the accumulator overflows is one tick longer.

Software reaches the core through a simple register bus. A write completes in one clock; a read is combinational on the byte offset. A new time value written by software does not replace the running count at once. It is held and loaded at the next one-second boundary, so the seconds count never jumps partway through a second.

The core also compares the count against an alarm value. It keeps a once-per-second event flag and an alarm event flag. Each flag has its own mask, controlled through separate enable and disable registers, and each drives its own interrupt line. A control register holds two spare configuration bits for the power and oscillator logic around the core.

Top module: `cal_rtc`

## Requirements
- R1: The calibration register is written at byte offset 0x08 and read back at 0x0C. Only bits [20:0] are stored, so writing 0xFFFFFFFF reads back 0x001FFFFF.
- R2: The calibration integer N sits in bits [15:0]. When N is non-zero, the tick counter advances on each tick-enable pulse from 0 up to N. On the next pulse it wraps to 0 and closes the second, so a second lasts N+1 pulses. The counter holds while tick-enable is low and reads at offset 0x14.
- R3: While N is 0 (the reset value), the prescaler is idle. The tick count reads 0 and the seconds count does not advance, whatever tick-enable does.
- R4: The fraction F sits in bits [19:16] and is enabled by bit 20. When enabled, F is added to a 4-bit accumulator that starts at 0. A second in which the addition overflows lasts N+2 pulses. With bit 20 clear, F has no effect.
- R5: The current seconds count reads at offset 0x10, is 0 after reset and increases by one at each second boundary.
- R6: A write to offset 0x00 does not change the seconds count at once. At the next second boundary, the seconds count takes the written value instead of incrementing. Offset 0x04 returns the written value.
- R7: The alarm value is at offset 0x18. Status bit 1 is set at the second boundary whose new seconds count equals the alarm value.
- R8: Status, at offset 0x20, sets bit 0 at every second boundary. Writing 1 to a status bit clears it. If a hardware set and a clear hit the same bit in the same cycle, the bit stays set.
- R9: The mask reads at offset 0x24 and is 0b11 (both masked) after reset. Writing 1 to a bit at offset 0x28 unmasks that interrupt. Writing 1 to a bit at offset 0x2C masks it.
- R10: irq_sec is high while status bit 0 is set and mask bit 0 is clear. irq_alarm follows the same rule for bit 1. Status bits are set even while masked.
- R11: The control register at offset 0x40 stores bits 31 and 24 and reads all other bits as 0. It has no effect on timekeeping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tick_en | input | 1 | One pulse per oscillator tick |
| irq_sec | output | 1 | Once-per-second interrupt |
| irq_alarm | output | 1 | Alarm interrupt |

## Verification
The bench builds the core with its default parameters: a 16-bit tick field, a 4-bit fraction and a 32-bit seconds count. It then programs a calibration integer of 3, so one second lasts only four tick pulses. This makes many seconds cheap to run. The bench can therefore step through whole fractional-accumulator patterns (4,5,4,5 for one fraction and 4,4,4,5 for another), a deferred load followed by an alarm match, and the same-cycle collision between a second boundary and a status clear.

// File: rtl/cal_rtc_pkg.sv
// Package: shared offsets and bit positions for the calibrated RTC.
// Assumes byte-offset addressing of 32-bit registers.
package cal_rtc_pkg;
    localparam int unsigned REG_W        = 32;
    localparam int unsigned OFS_SET_WR   = 'h00;
    localparam int unsigned OFS_SET_RD   = 'h04;
    localparam int unsigned OFS_CAL_WR   = 'h08;
    localparam int unsigned OFS_CAL_RD   = 'h0C;
    localparam int unsigned OFS_CUR_SEC  = 'h10;
    localparam int unsigned OFS_CUR_TICK = 'h14;
    localparam int unsigned OFS_ALARM    = 'h18;
    localparam int unsigned OFS_STATUS   = 'h20;
    localparam int unsigned OFS_MASK     = 'h24;
    localparam int unsigned OFS_UNMASK   = 'h28;
    localparam int unsigned OFS_DOMASK   = 'h2C;
    localparam int unsigned OFS_CTRL     = 'h40;
    localparam int unsigned EVT_SEC      = 0;
    localparam int unsigned EVT_ALARM    = 1;
    localparam int unsigned NUM_EVT      = 2;
    localparam int unsigned CTRL_PWR_BIT = 31;
    localparam int unsigned CTRL_OSC_BIT = 24;
endpackage

// File: rtl/cal_rtc_prescale.sv
// Module: tick prescaler with fractional compensation.
// Counts tick_en pulses from 0 to the calibration integer (plus one
// extra tick in seconds where the fraction accumulator overflows) and
// pulses sec_stb on the wrapping tick. Assumes calib_int==0 means idle.
module cal_rtc_prescale #(
    parameter int unsigned TICK_W = 16,
    parameter int unsigned FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [TICK_W-1:0] calib_int,
    input  logic [FRAC_W-1:0] frac,
    input  logic              frac_en,
    output logic [TICK_W:0]   tick_cnt,
    output logic              sec_stb
);
    localparam int unsigned CNT_W = TICK_W + 1;

    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   acc_sum;
    logic              carry;
    logic [CNT_W-1:0]  limit;
    logic              running;
    logic              at_end;

    // Purpose: work out this second's length and whether it ends now.
    always_comb begin
        acc_sum = {1'b0, acc_q} + {1'b0, frac};
        carry   = frac_en & acc_sum[FRAC_W];
        limit   = {1'b0, calib_int} + CNT_W'(carry);
        running = |calib_int;
        at_end  = (tick_cnt >= limit);
        sec_stb = running & tick_en & at_end;
    end

    // Purpose: advance or wrap the tick counter, clear it while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !running) begin
            tick_cnt <= '0;
        end else if (tick_en) begin
            tick_cnt <= at_end ? '0 : tick_cnt + CNT_W'(1);
        end
    end

    // Purpose: accumulate the fraction once per compensated second.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (sec_stb && frac_en) begin
            acc_q <= acc_sum[FRAC_W-1:0];
        end
    end
endmodule

// File: rtl/cal_rtc_seconds.sv
// Module: seconds counter with deferred load and alarm compare.
// A loaded value is held pending and replaces the increment at the next
// second strobe. alarm_hit flags the strobe whose new count equals alarm.
module cal_rtc_seconds #(
    parameter int unsigned SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_stb,
    input  logic             load_we,
    input  logic [SEC_W-1:0] load_val,
    input  logic [SEC_W-1:0] alarm_val,
    output logic [SEC_W-1:0] cur_sec,
    output logic [SEC_W-1:0] set_val,
    output logic             load_pend,
    output logic             alarm_hit
);
    logic [SEC_W-1:0] next_sec;

    // Purpose: choose the value the count takes at the next boundary.
    always_comb begin
        next_sec  = load_pend ? set_val : cur_sec + SEC_W'(1);
        alarm_hit = sec_stb && (next_sec == alarm_val);
    end

    // Purpose: update the running seconds count at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_sec <= '0;
        end else if (sec_stb) begin
            cur_sec <= next_sec;
        end
    end

    // Purpose: capture a new time and track whether it awaits a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_val   <= '0;
            load_pend <= 1'b0;
        end else begin
            if (load_we) begin
                set_val <= load_val;
            end
            if (load_we) begin
                load_pend <= 1'b1;
            end else if (sec_stb) begin
                load_pend <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cal_rtc_irq.sv
// Module: event status with write-one-to-clear and a mask set and
// cleared through separate strobes. A hardware set beats a clear in
// the same cycle. Assumes at most one of unmask/domask per cycle.
module cal_rtc_irq #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_set,
    input  logic [N-1:0] evt_clr,
    input  logic [N-1:0] unmask,
    input  logic [N-1:0] domask,
    output logic [N-1:0] status,
    output logic [N-1:0] mask,
    output logic [N-1:0] irq
);
    // Purpose: per-event status and mask bits.
    for (genvar i = 0; i < N; i++) begin : g_evt
        // Purpose: set on event, clear on write-one, set wins.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                status[i] <= 1'b0;
            end else if (evt_set[i]) begin
                status[i] <= 1'b1;
            end else if (evt_clr[i]) begin
                status[i] <= 1'b0;
            end
        end

        // Purpose: mask bit, masked out of reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask[i] <= 1'b1;
            end else if (domask[i]) begin
                mask[i] <= 1'b1;
            end else if (unmask[i]) begin
                mask[i] <= 1'b0;
            end
        end

        // Purpose: drive the line while pending and unmasked.
        always_comb irq[i] = status[i] & ~mask[i];
    end
endmodule

// File: rtl/cal_rtc.sv
// Module: calibrated real-time clock core, register front end.
// Decodes byte offsets of a one-cycle write / combinational read bus,
// holds calibration, alarm and control registers, and ties together
// prescaler, seconds counter and event logic. Assumes SEC_W <= 32 and
// TICK_W + FRAC_W + 1 <= 32.
module cal_rtc import cal_rtc_pkg::*; #(
    parameter int unsigned TICK_W = 16,
    parameter int unsigned FRAC_W = 4,
    parameter int unsigned SEC_W  = 32,
    parameter int unsigned ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              tick_en,
    output logic              irq_sec,
    output logic              irq_alarm
);
    localparam int unsigned CAL_W   = TICK_W + FRAC_W + 1;
    localparam int unsigned FEN_BIT = TICK_W + FRAC_W;

    logic               wr_set, wr_cal, wr_alarm, wr_sts, wr_unm, wr_msk, wr_ctrl;
    logic [CAL_W-1:0]   calib_q;
    logic [SEC_W-1:0]   alarm_q;
    logic               ctrl_pwr, ctrl_osc;
    logic [TICK_W-1:0]  calib_int;
    logic [TICK_W:0]    tick_cnt;
    logic               sec_stb;
    logic [SEC_W-1:0]   cur_sec, set_val;
    logic               load_pend, alarm_hit;
    logic [NUM_EVT-1:0] evt_set, evt_clr, unmask, domask;
    logic [NUM_EVT-1:0] status, mask, irq;

    // Purpose: decode write strobes from the byte offset.
    always_comb begin
        wr_set   = bus_we && (bus_addr == ADDR_W'(OFS_SET_WR));
        wr_cal   = bus_we && (bus_addr == ADDR_W'(OFS_CAL_WR));
        wr_alarm = bus_we && (bus_addr == ADDR_W'(OFS_ALARM));
        wr_sts   = bus_we && (bus_addr == ADDR_W'(OFS_STATUS));
        wr_unm   = bus_we && (bus_addr == ADDR_W'(OFS_UNMASK));
        wr_msk   = bus_we && (bus_addr == ADDR_W'(OFS_DOMASK));
        wr_ctrl  = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
    end

    // Purpose: calibration, alarm and control storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            calib_q  <= '0;
            alarm_q  <= '0;
            ctrl_pwr <= 1'b0;
            ctrl_osc <= 1'b0;
        end else begin
            if (wr_cal)   calib_q <= bus_wdata[CAL_W-1:0];
            if (wr_alarm) alarm_q <= bus_wdata[SEC_W-1:0];
            if (wr_ctrl) begin
                ctrl_pwr <= bus_wdata[CTRL_PWR_BIT];
                ctrl_osc <= bus_wdata[CTRL_OSC_BIT];
            end
        end
    end

    always_comb calib_int = calib_q[TICK_W-1:0];

    cal_rtc_prescale #(.TICK_W(TICK_W), .FRAC_W(FRAC_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .calib_int(calib_int),
        .frac     (calib_q[FEN_BIT-1:TICK_W]),
        .frac_en  (calib_q[FEN_BIT]),
        .tick_cnt (tick_cnt),
        .sec_stb  (sec_stb)
    );

    cal_rtc_seconds #(.SEC_W(SEC_W)) u_sec (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_stb  (sec_stb),
        .load_we  (wr_set),
        .load_val (bus_wdata[SEC_W-1:0]),
        .alarm_val(alarm_q),
        .cur_sec  (cur_sec),
        .set_val  (set_val),
        .load_pend(load_pend),
        .alarm_hit(alarm_hit)
    );

    // Purpose: route events and bus strobes into the event block.
    always_comb begin
        evt_set            = '0;
        evt_set[EVT_SEC]   = sec_stb;
        evt_set[EVT_ALARM] = alarm_hit;
        evt_clr = wr_sts ? bus_wdata[NUM_EVT-1:0] : '0;
        unmask  = wr_unm ? bus_wdata[NUM_EVT-1:0] : '0;
        domask  = wr_msk ? bus_wdata[NUM_EVT-1:0] : '0;
    end

    cal_rtc_irq #(.N(NUM_EVT)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_set(evt_set),
        .evt_clr(evt_clr),
        .unmask (unmask),
        .domask (domask),
        .status (status),
        .mask   (mask),
        .irq    (irq)
    );

    always_comb irq_sec   = irq[EVT_SEC];
    always_comb irq_alarm = irq[EVT_ALARM];

    // Purpose: combinational read mux over byte offsets.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_SET_RD):   bus_rdata = REG_W'(set_val);
            ADDR_W'(OFS_CAL_RD):   bus_rdata = REG_W'(calib_q);
            ADDR_W'(OFS_CUR_SEC):  bus_rdata = REG_W'(cur_sec);
            ADDR_W'(OFS_CUR_TICK): bus_rdata = REG_W'(tick_cnt);
            ADDR_W'(OFS_ALARM):    bus_rdata = REG_W'(alarm_q);
            ADDR_W'(OFS_STATUS):   bus_rdata = REG_W'(status);
            ADDR_W'(OFS_MASK):     bus_rdata = REG_W'(mask);
            ADDR_W'(OFS_CTRL): begin
                bus_rdata[CTRL_PWR_BIT] = ctrl_pwr;
                bus_rdata[CTRL_OSC_BIT] = ctrl_osc;
            end
            default:               bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cal_rtc_chk.sv
// Module: assertion checker for cal_rtc, attached by bind.
// Observes the seconds strobe, counter, pending load and event state.
module cal_rtc_chk #(
    parameter int unsigned TICK_W = 16,
    parameter int unsigned SEC_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sec_stb,
    input logic              alarm_hit,
    input logic              wr_set,
    input logic              load_pend,
    input logic [SEC_W-1:0]  cur_sec,
    input logic [SEC_W-1:0]  set_val,
    input logic [TICK_W-1:0] calib_int,
    input logic [TICK_W:0]   tick_cnt,
    input logic [1:0]        status,
    input logic [1:0]        mask,
    input logic              irq_alarm
);
    // R8: a boundary always leaves the seconds event pending.
    assert_sec_evt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sec_stb |=> status[0]);

    // R5: without a pending load the count steps by one.
    assert_count_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_stb && !load_pend) |=> (cur_sec == $past(cur_sec) + SEC_W'(1)));

    // R5: the count only moves on a boundary.
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_stb |=> $stable(cur_sec));

    // R6: a pending value is taken at the boundary and the flag drops.
    assert_deferred_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_stb && load_pend && !wr_set) |=> (cur_sec == $past(set_val) && !load_pend));

    // R3: a zero calibration parks the tick counter at zero.
    assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (calib_int == '0) |=> (tick_cnt == '0));

    // R7: an alarm match leaves the alarm event pending.
    assert_alarm_evt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |=> status[1]);

    // R10: a masked alarm never reaches its line.
    assert_alarm_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mask[1] |-> !irq_alarm);
endmodule

bind cal_rtc cal_rtc_chk #(.TICK_W(TICK_W), .SEC_W(SEC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_stb  (sec_stb),
    .alarm_hit(alarm_hit),
    .wr_set   (wr_set),
    .load_pend(load_pend),
    .cur_sec  (cur_sec),
    .set_val  (set_val),
    .calib_int(calib_int),
    .tick_cnt (tick_cnt),
    .status   (status),
    .mask     (mask),
    .irq_alarm(irq_alarm)
);

// File: tb/sim_cal_rtc.sv
`timescale 1ns/1ps
// Bench: directed scenarios for cal_rtc, one task each.
module sim_cal_rtc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_en = 1'b0;
    logic        irq_sec, irq_alarm;
    int          n_tests = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    cal_rtc u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
        .irq_sec(irq_sec), .irq_alarm(irq_alarm)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    // Counts tick pulses until the seconds register changes.
    task automatic sec_len(output int n);
        logic [31:0] start;
        rd(7'h10, start);
        n = 0;
        for (int i = 0; i < 40; i++) begin
            ticks(1);
            n++;
            #1;
            if (bus_rdata != start) break;
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(7'h0C, d); check("R3 calib reset", d, 0);
        rd(7'h24, d); check("R9 mask reset", d, 3);
        rd(7'h10, d); check("R5 seconds reset", d, 0);
        check("R10 irq lines reset", {30'd0, irq_sec, irq_alarm}, 0);
        ticks(5);
        rd(7'h14, d); check("R3 idle tick count", d, 0);
        rd(7'h10, d); check("R3 idle seconds", d, 0);
    endtask

    task automatic t_count;
        logic [31:0] d;
        wr(7'h08, 32'd3);
        ticks(3);
        rd(7'h14, d); check("R2 tick count at N", d, 3);
        rd(7'h10, d); check("R2 no second before wrap", d, 0);
        ticks(1);
        rd(7'h10, d); check("R5 second after N+1 ticks", d, 1);
        rd(7'h14, d); check("R2 tick count wrapped", d, 0);
        rd(7'h20, d); check("R8 seconds event set", d, 1);
        check("R10 masked seconds line", {31'd0, irq_sec}, 0);
        ticks(2);
        repeat (6) @(negedge clk);
        rd(7'h14, d); check("R2 count holds without ticks", d, 2);
        ticks(2);
        rd(7'h10, d); check("R5 second increment", d, 2);
    endtask

    task automatic t_irq;
        logic [31:0] d;
        wr(7'h28, 32'd1);
        rd(7'h24, d); check("R9 unmask seconds", d, 2);
        check("R10 seconds line high", {31'd0, irq_sec}, 1);
        wr(7'h20, 32'd1);
        rd(7'h20, d); check("R8 write-one clears", d, 0);
        check("R10 seconds line low after clear", {31'd0, irq_sec}, 0);
        ticks(3);
        @(negedge clk);
        tick_en = 1'b1; bus_we = 1'b1; bus_addr = 7'h20; bus_wdata = 32'd1;
        @(negedge clk);
        tick_en = 1'b0; bus_we = 1'b0;
        rd(7'h20, d); check("R8 set beats clear", d, 1);
        rd(7'h10, d); check("R5 seconds at collision", d, 3);
        wr(7'h2C, 32'd1);
        rd(7'h24, d); check("R9 re-mask seconds", d, 3);
        check("R10 masked line drops", {31'd0, irq_sec}, 0);
        rd(7'h20, d); check("R10 status kept while masked", d, 1);
        wr(7'h20, 32'd3);
    endtask

    task automatic t_load;
        logic [31:0] d;
        wr(7'h00, 32'd100);
        rd(7'h10, d); check("R6 no immediate load", d, 3);
        rd(7'h04, d); check("R6 readback of written time", d, 100);
        ticks(3);
        rd(7'h10, d); check("R6 still deferred", d, 3);
        ticks(1);
        rd(7'h10, d); check("R6 loaded at boundary", d, 100);
        ticks(4);
        rd(7'h10, d); check("R6 counts on from load", d, 101);
    endtask

    task automatic t_alarm;
        logic [31:0] d;
        wr(7'h18, 32'd103);
        wr(7'h20, 32'd3);
        ticks(4);
        rd(7'h20, d); check("R7 no alarm before match", d & 2, 0);
        ticks(4);
        rd(7'h10, d); check("R7 seconds at match", d, 103);
        rd(7'h20, d); check("R7 alarm event", d & 2, 2);
        check("R10 masked alarm line", {31'd0, irq_alarm}, 0);
        wr(7'h28, 32'd2);
        check("R10 alarm line high", {31'd0, irq_alarm}, 1);
        wr(7'h20, 32'd2);
        check("R10 alarm line after clear", {31'd0, irq_alarm}, 0);
        wr(7'h2C, 32'd2);
    endtask

    task automatic t_frac;
        int n;
        int exp8[4] = '{4, 5, 4, 5};
        int exp4[4] = '{4, 4, 4, 5};
        wr(7'h08, 32'h0018_0003);
        for (int i = 0; i < 4; i++) begin
            sec_len(n); check("R4 fraction 8/16 lengths", n, exp8[i]);
        end
        wr(7'h08, 32'h0014_0003);
        for (int i = 0; i < 4; i++) begin
            sec_len(n); check("R4 fraction 4/16 lengths", n, exp4[i]);
        end
        wr(7'h08, 32'h0008_0003);
        for (int i = 0; i < 2; i++) begin
            sec_len(n); check("R4 fraction disabled", n, 4);
        end
    endtask

    task automatic t_calib;
        logic [31:0] d, s;
        int n;
        wr(7'h08, 32'hFFFF_FFFF);
        rd(7'h0C, d); check("R1 calib field width", d, 32'h001F_FFFF);
        wr(7'h08, 32'd0);
        rd(7'h10, s);
        ticks(10);
        rd(7'h10, d); check("R3 zero calib stops seconds", d, s);
        rd(7'h14, d); check("R3 zero calib tick count", d, 0);
        wr(7'h08, 32'd3);
        wr(7'h40, 32'hFFFF_FFFF);
        rd(7'h40, d); check("R11 control bits", d, 32'h8100_0000);
        sec_len(n); check("R11 control no timing effect", n, 4);
        wr(7'h40, 32'd0);
        rd(7'h40, d); check("R11 control cleared", d, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count();
        t_irq();
        t_load();
        t_alarm();
        t_frac();
        t_calib();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule